// File: doc/BRIEF.md
# Serial Channel Wait/Ready Handshake

This block drives the bus handshake pin of one serial channel. The pin serves one of two purposes. As a DMA ready request, it is a push-pull level that goes low when the channel wants a transfer. As a CPU wait request, it is an open-drain pull-down that stalls a processor access the channel cannot yet serve. A three-bit control field selects the purpose. The field holds an enable, a function select and a direction select. The direction select decides whether the pin tracks the transmit buffer or the receive buffer.

The ready level depends only on buffer state, so it can go active while the chip is not being addressed. The wait pull-down acts only while this channel's data port is the target of a live I/O request. Each mode keeps its own clock-edge alignment. Ready asserts on a rising edge and is withdrawn by the data access itself. Wait asserts as soon as the access appears and lets go on a falling edge. A change of function while the pin is active first passes through one cycle with the pin inactive, so the pin cannot glitch from one meaning to the other.

Top module: `chan_handshake`

## Requirements
- R1: After reset, whether the reset is asserted asynchronously or held, the control field is 0, `readyN` is 1 and `waitPullDn` is 0.
- R2: A write with `cfgWrEn` high loads `cfgWrData` on the next rising clock edge. Bit 2 of the field is the enable. Bit 1 is the function: 1 selects ready, 0 selects wait. Bit 0 is the direction: 1 follows the receive buffer, 0 follows the transmit buffer.
- R3: While the enable is 0, `readyN` stays 1 and `waitPullDn` stays 0 for every buffer state and every access.
- R4: In ready mode with no data access, `readyN` is 0 once it has asserted, provided one of two conditions holds: direction 0 with `txFull` 0, or direction 1 with `rxFull` 1. Otherwise `readyN` is 1, and it rises as soon as the condition goes false. `portSel` without `ioReqN` low has no effect on it.
- R5: `readyN` falls only on a rising clock edge: the first one at which the ready condition is true.
- R6: A data access means `portSel` is 1 while `ioReqN` is 0. A data access forces `readyN` to 1 at once. `readyN` stays 1 after the access ends and falls again no earlier than the next rising edge.
- R7: In wait mode, `waitPullDn` goes to 1 with no clock edge during a data access, provided one of two conditions holds: direction 0 with `txFull` 1, or direction 1 with `rxFull` 0. In all other cases wait mode leaves it at 0.
- R8: When the wait condition ends, `waitPullDn` stays 1 until the next falling clock edge and is 0 after it.
- R9: A write that changes the function bit while enabled and while the pin is active first holds the enable at 0 for one cycle. The written value takes effect on the following rising edge. A write arriving during that cycle replaces the staged value.
- R10: Any other write takes effect directly on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control field write strobe |
| cfgWrData | input | 3 | Control field value: enable, function, direction |
| txFull | input | 1 | Transmit buffer holds a character |
| rxFull | input | 1 | Receive buffer holds a character |
| portSel | input | 1 | This channel's data port is addressed |
| ioReqN | input | 1 | I/O request strobe, active low |
| readyN | output | 1 | DMA ready level, active low |
| waitPullDn | output | 1 | Enable of the open-drain wait pull-down |

## Verification
A wrong stored control field shows up within one rising edge: the pin follows the wrong buffer or the wrong mode under the first buffer pattern that tells them apart. A stuck ready flag shows up in one of two ways. Either `readyN` falls in the half-cycle after an access instead of waiting for the next rising edge, or it fails to fall at that edge. A wrong wait hold register moves the release of `waitPullDn` to the wrong half of the clock. A missing staging cycle appears as the new mode taking effect one cycle early, right at the write edge.

// File: rtl/hs_pkg.sv
`timescale 1ns/100ps
package hs_pkg;
  parameter int CFG_W   = 3;
  parameter int EN_BIT  = 2;
  parameter int FN_BIT  = 1;
  parameter int DIR_BIT = 0;

  typedef struct packed {
    logic enable;
    logic readyMode;
    logic followRx;
  } hsCfg_t;

  typedef struct packed {
    logic enable;
    logic readyMode;
    logic followRx;
    logic dataAccess;
  } hsStrb_t;

  function automatic hsCfg_t unpackCfg(input logic [CFG_W-1:0] raw);
    hsCfg_t c;
    c.enable    = raw[EN_BIT];
    c.readyMode = raw[FN_BIT];
    c.followRx  = raw[DIR_BIT];
    return c;
  endfunction
endpackage

// File: rtl/hs_ctrl.sv
`timescale 1ns/100ps
module hs_ctrl
  import hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             portSel,
  input  logic             ioReqN,
  input  logic             pinActive,
  output hsStrb_t          strb
);
  hsCfg_t cfgEff;
  hsCfg_t cfgStaged;
  logic   pending;
  hsCfg_t newCfg;
  logic   needStage;

  assign newCfg    = unpackCfg(cfgWrData);
  assign needStage = pinActive && cfgEff.enable && (newCfg.readyMode != cfgEff.readyMode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgEff    <= '0;
      cfgStaged <= '0;
      pending   <= 1'b0;
    end else if (pending) begin
      cfgEff  <= cfgWrEn ? newCfg : cfgStaged;
      pending <= 1'b0;
    end else if (cfgWrEn) begin
      if (needStage) begin
        cfgEff.enable <= 1'b0;
        cfgStaged     <= newCfg;
        pending       <= 1'b1;
      end else begin
        cfgEff <= newCfg;
      end
    end
  end

  always_comb begin
    strb.enable     = cfgEff.enable;
    strb.readyMode  = cfgEff.readyMode;
    strb.followRx   = cfgEff.followRx;
    strb.dataAccess = portSel && !ioReqN;
  end

  // R9: the staging interval never lasts longer than one cycle
  assert_stage_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !pending);

  // R9: during staging the pin is held disabled
  assert_stage_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !strb.enable);

  // R10: a plain write lands unchanged on the next edge
  assert_direct_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && !pending && !needStage) |=> (cfgEff == $past(newCfg)));
endmodule

// File: rtl/hs_path.sv
`timescale 1ns/100ps
module hs_path
  import hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  hsStrb_t strb,
  input  logic    txFull,
  input  logic    rxFull,
  output logic    readyN,
  output logic    waitPullDn,
  output logic    pinActive
);
  logic readyCond;
  logic readyActive;
  logic readyOn;
  logic waitCond;
  logic waitHold;

  // ready: condition from buffer state only, asserted at a rising edge
  assign readyCond = strb.enable && strb.readyMode &&
                     (strb.followRx ? rxFull : !txFull);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readyActive <= 1'b0;
    else        readyActive <= readyCond && !strb.dataAccess;
  end

  assign readyOn = readyActive && readyCond && !strb.dataAccess;
  assign readyN  = !readyOn;

  // wait: asserted by the access itself, held to the next falling edge
  assign waitCond = strb.enable && !strb.readyMode && strb.dataAccess &&
                    (strb.followRx ? !rxFull : txFull);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) waitHold <= 1'b0;
    else        waitHold <= waitCond;
  end

  assign waitPullDn = waitCond || (waitHold && strb.enable && !strb.readyMode);
  assign pinActive  = readyOn || waitPullDn;

  // R3: a disabled field keeps the pin idle
  assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.enable |-> (readyN && !waitPullDn));

  // R5: ready can only have fallen after a cycle spent enabled in ready mode
  assert_ready_fall_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(readyN) |-> $past(strb.enable && strb.readyMode));

  // R6: an access in progress never sees ready low
  assert_access_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dataAccess |-> readyN);

  // R7: the two functions never drive the pin at once
  assert_modes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!readyN && waitPullDn));
endmodule

// File: rtl/chan_handshake.sv
`timescale 1ns/100ps
module chan_handshake
  import hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             txFull,
  input  logic             rxFull,
  input  logic             portSel,
  input  logic             ioReqN,
  output logic             readyN,
  output logic             waitPullDn
);
  hsStrb_t strb;
  logic    pinActive;

  hs_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .portSel   (portSel),
    .ioReqN    (ioReqN),
    .pinActive (pinActive),
    .strb      (strb)
  );

  hs_path u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .txFull     (txFull),
    .rxFull     (rxFull),
    .readyN     (readyN),
    .waitPullDn (waitPullDn),
    .pinActive  (pinActive)
  );
endmodule

// File: tb/chan_handshake_bench.sv
`timescale 1ns/100ps
module chan_handshake_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgWrData = 3'd0;
  logic       txFull = 1'b0;
  logic       rxFull = 1'b0;
  logic       portSel = 1'b0;
  logic       ioReqN = 1'b1;
  logic       readyN;
  logic       waitPullDn;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chan_handshake u_chan_handshake (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .txFull(txFull), .rxFull(rxFull), .portSel(portSel), .ioReqN(ioReqN),
    .readyN(readyN), .waitPullDn(waitPullDn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit expReadyLow(input logic [2:0] c, input logic tx, input logic rx);
    return c[2] && c[1] && (c[0] ? rx : !tx);
  endfunction

  function automatic bit expWait(input logic [2:0] c, input logic tx, input logic rx);
    return c[2] && !c[1] && (c[0] ? !rx : tx);
  endfunction

  task automatic edgeP(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic writeCfg(input logic [2:0] v);
    cfgWrData = v; cfgWrEn = 1'b1;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic access(input logic on);
    portSel = on; ioReqN = !on;
  endtask

  initial begin
    #1;
    chk("R1 reset readyN", readyN, 1);
    chk("R1 reset wait", waitPullDn, 0);
    edgeP(2);
    rst_n = 1'b1;
    edgeP(2);
    chk("R1 after release readyN", readyN, 1);
    chk("R1 after release wait", waitPullDn, 0);

    // exhaustive sweep: field value x buffer states, with and without access
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 4; b++) begin
        logic [2:0] cv;
        logic tx, rx;
        cv = c[2:0]; tx = b[0]; rx = b[1];
        access(1'b0);
        writeCfg(3'd0);
        edgeP(3);
        txFull = tx; rxFull = rx;
        writeCfg(cv);
        edgeP(2);
        chk($sformatf("R4 R3 R2 idle readyN cfg=%0d b=%0d", c, b), readyN, !expReadyLow(cv, tx, rx));
        chk($sformatf("R3 idle wait cfg=%0d b=%0d", c, b), waitPullDn, 0);
        portSel = 1'b1;
        #0.5;
        chk($sformatf("R4 portSel alone cfg=%0d b=%0d", c, b), readyN, !expReadyLow(cv, tx, rx));
        access(1'b1);
        #0.5;
        chk($sformatf("R6 access readyN cfg=%0d b=%0d", c, b), readyN, 1);
        chk($sformatf("R7 access wait cfg=%0d b=%0d", c, b), waitPullDn, expWait(cv, tx, rx));
        @(posedge clk); #1;
        access(1'b0);
        #0.5;
        chk($sformatf("R8 hold wait cfg=%0d b=%0d", c, b), waitPullDn, expWait(cv, tx, rx));
        chk($sformatf("R6 post access readyN cfg=%0d b=%0d", c, b), readyN, 1);
        @(negedge clk); #0.5;
        chk($sformatf("R8 released wait cfg=%0d b=%0d", c, b), waitPullDn, 0);
        chk($sformatf("R6 still high cfg=%0d b=%0d", c, b), readyN, 1);
        @(posedge clk); #0.5;
        chk($sformatf("R5 reassert cfg=%0d b=%0d", c, b), readyN, !expReadyLow(cv, tx, rx));
      end
    end

    // R5: ready falls only at a rising edge; R4: rises at once on condition loss
    access(1'b0); writeCfg(3'd0); edgeP(2);
    txFull = 1'b1; rxFull = 1'b0;
    writeCfg(3'b110); edgeP(2);
    chk("R4 tx full ready high", readyN, 1);
    @(negedge clk); #0.5;
    txFull = 1'b0;
    #0.5;
    chk("R5 no fall before edge", readyN, 1);
    @(posedge clk); #0.5;
    chk("R5 fall at rising edge", readyN, 0);
    txFull = 1'b1;
    #0.5;
    chk("R4 immediate rise on full", readyN, 1);
    txFull = 1'b0;
    edgeP(2);
    chk("R4 ready active again", readyN, 0);

    // R9: function change while active passes through a disabled cycle
    txFull = 1'b1;
    cfgWrData = 3'b100; cfgWrEn = 1'b1;
    txFull = 1'b0;
    @(posedge clk); #0.5;
    cfgWrEn = 1'b0;
    chk("R9 staged readyN high", readyN, 1);
    txFull = 1'b1; access(1'b1);
    #0.5;
    chk("R9 staged wait idle", waitPullDn, 0);
    @(posedge clk); #0.5;
    chk("R9 new mode wait asserts", waitPullDn, 1);
    chk("R9 new mode ready idle", readyN, 1);
    @(posedge clk); #1;
    access(1'b0);
    @(negedge clk); #0.5;
    chk("R8 release after staging", waitPullDn, 0);

    // R10: direct write while inactive applies at the next edge
    rxFull = 1'b0;
    writeCfg(3'b101);
    access(1'b1);
    #0.5;
    chk("R10 direct rx wait", waitPullDn, 1);
    access(1'b0);
    edgeP(2);

    // R1: asynchronous reset while ready is active
    writeCfg(3'b111); rxFull = 1'b1; edgeP(2);
    chk("R1 pre reset active", readyN, 0);
    #0.5; rst_n = 1'b0; #0.5;
    chk("R1 async reset readyN", readyN, 1);
    rst_n = 1'b1;
    edgeP(2);
    chk("R1 field cleared", readyN, 1);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule